// File: doc/BRIEF.md
# UDP/IPv4 Ethernet Frame Transmitter

This block emits one complete Ethernet frame carrying a UDP datagram inside an IPv4 packet, one byte per clock, towards a byte-wide MAC transmit client port that uses active-low start-of-frame, end-of-frame and source-ready strobes. Addresses, ports, the EtherType and most IPv4 fields are elaboration-time parameters and come out of a constant header table. Only three header fields depend on the payload length, and each costs one small adder or subtractor: the IPv4 Total Length, the IPv4 header checksum and the UDP Length.

A frame begins when `start_i` is seen high while the block is idle. The payload length on `len_i` is captured at that moment. The first header byte leaves on the very next cycle, with nothing staged beforehand. Two cycles before the payload needs its first byte, the block pulses `data_req_o`. From then on it forwards whatever is on `usr_data_i`, one byte per cycle, until the payload is done.

The output stream has no back-pressure. `src_rdy_n_o` low means a valid byte, and the MAC must take a byte on every cycle of the frame. The user side works the same way: the user must place payload bytes on `usr_data_i` at the announced cycles, because the block does not wait for them.

Top module: `udp_frame_tx`

## Requirements
- R1: A frame is 42 header bytes followed by the payload, one byte per cycle, in this order: destination MAC (6 bytes), source MAC (6), EtherType 0x0800, then the 20-byte IPv4 header (0x45, 0x00, Total Length, identification, flags/fragment, TTL, protocol 0x11, checksum, source IP, destination IP), then the 8-byte UDP header (source port, destination port, UDP Length, checksum). Every multi-byte field goes most significant byte first.
- R2: If `start_i` is high at a rising edge while idle, frame byte 0 appears during the following cycle. `sof_n_o` is low during that cycle only.
- R3: Frame bytes 16 and 17 carry the IPv4 Total Length, which is 28 plus the captured payload length L.
- R4: Frame bytes 24 and 25 carry the IPv4 header checksum. It must equal the ones'-complement of the end-around-carry sum of the ten 16-bit header words (checksum word taken as zero), for every L from 0 to 2047.
- R5: Frame bytes 38 and 39 carry the UDP Length, which is 8 plus L. Bytes 40 and 41 are zero.
- R6: `data_req_o` is high for exactly one cycle, the cycle of frame byte 40, so two cycles ahead of the first payload byte (byte 42). It is not raised when L is 0.
- R7: During frame bytes 42 to 41+L, `tx_data_o` equals `usr_data_i` in the same cycle. Values of `usr_data_i` at any other time never reach `tx_data_o`.
- R8: `eof_n_o` is low only during the last byte of a frame, which is byte 41+L (byte 41 when L is 0).
- R9: `src_rdy_n_o` is low from the `sof_n_o` byte through the `eof_n_o` byte, inclusive. While it is high, `tx_data_o` is 0x00 and `data_req_o` is low.
- R10: Changes on `len_i` after the start cycle do not alter the frame in progress.
- R11: `start_i` has no effect while a frame is in progress, including during its last byte. A `start_i` seen in the first idle cycle after a frame starts the next frame, which leaves exactly one idle cycle between the two frames.
- R12: While `rst_n` is low and after it is released, the block is idle: all three active-low strobes are high, `data_req_o` is low and `tx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request, honoured only while idle |
| len_i | input | LEN_W (11) | Payload byte count, captured with the request |
| usr_data_i | input | 8 | Payload byte, forwarded during the payload window |
| data_req_o | output | 1 | One-cycle pulse two cycles before the first payload byte |
| tx_data_o | output | 8 | Frame byte towards the MAC client port |
| sof_n_o | output | 1 | Active-low first-byte marker |
| eof_n_o | output | 1 | Active-low last-byte marker |
| src_rdy_n_o | output | 1 | Active-low byte-valid, low for the whole frame |

## Verification
A byte index that is wrong by one moves every field at once. The next header byte would come from the neighbouring table entry, and the error would be visible on `tx_data_o` within one cycle of the fault. A wrong captured length does not appear until byte 16, where the Total Length is sent. It then also corrupts the checksum at byte 24, the UDP Length at byte 38, the request pulse and the position of `eof_n_o`. A stuck busy state shows as `src_rdy_n_o` staying low past `eof_n_o`, or as a frame that starts without a request. The scoreboard compares every frame byte and every strobe against values built from the length alone, so each of these faults is caught in the cycle where it first reaches the ports.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  localparam int ETH_BYTES  = 14;
  localparam int IP_BYTES   = 20;
  localparam int UDP_BYTES  = 8;
  localparam int HDR_BYTES  = ETH_BYTES + IP_BYTES + UDP_BYTES;

  // byte positions of computed fields (most significant byte)
  localparam int TOTLEN_POS = ETH_BYTES + 2;
  localparam int CSUM_POS   = ETH_BYTES + 10;
  localparam int UDPLEN_POS = ETH_BYTES + IP_BYTES + 4;

  localparam logic [7:0]  IP_VER_IHL = 8'h45;
  localparam logic [7:0]  IP_TOS     = 8'h00;
  localparam logic [7:0]  IP_PROTO   = 8'h11;
  localparam logic [15:0] ETH_TYPE   = 16'h0800;

  typedef enum logic [1:0] {
    SEL_TABLE  = 2'd0,
    SEL_TOTLEN = 2'd1,
    SEL_CSUM   = 2'd2,
    SEL_UDPLEN = 2'd3
  } fld_sel_e;

  function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // checksum of the header with a zero-payload total length
  function automatic logic [15:0] base_csum(
    input logic [15:0] ident,
    input logic [15:0] flags,
    input logic [7:0]  ttl,
    input logic [31:0] src_ip,
    input logic [31:0] dst_ip
  );
    logic [15:0] acc;
    acc = {IP_VER_IHL, IP_TOS};
    acc = ones_add(acc, 16'(IP_BYTES + UDP_BYTES));
    acc = ones_add(acc, ident);
    acc = ones_add(acc, flags);
    acc = ones_add(acc, {ttl, IP_PROTO});
    acc = ones_add(acc, src_ip[31:16]);
    acc = ones_add(acc, src_ip[15:0]);
    acc = ones_add(acc, dst_ip[31:16]);
    acc = ones_add(acc, dst_ip[15:0]);
    return ~acc;
  endfunction

endpackage

// File: rtl/udp_tx_seq.sv
module udp_tx_seq
  import udp_tx_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int IDX_W    = 12,
  parameter int REQ_LEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             in_payload_o,
  output logic             sof_n_o,
  output logic             eof_n_o,
  output logic             src_rdy_n_o,
  output logic             data_req_o
);

  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] REQ_IDX  = IDX_W'(HDR_BYTES - REQ_LEAD);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [LEN_W-1:0] len_q;
  logic             at_last;

  assign at_last = (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= HDR_LAST;
      len_q  <= '0;
    end else if (!busy_q) begin
      idx_q <= '0;
      if (start_i) begin
        busy_q <= 1'b1;
        len_q  <= len_i;
        last_q <= HDR_LAST + IDX_W'(len_i);
      end
    end else if (at_last) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign idx_o        = idx_q;
  assign len_o        = len_q;
  assign in_payload_o = busy_q && (idx_q >= HDR_END);
  assign sof_n_o      = !(busy_q && (idx_q == '0));
  assign eof_n_o      = !(busy_q && at_last);
  assign src_rdy_n_o  = !busy_q;
  assign data_req_o   = busy_q && (idx_q == REQ_IDX) && (len_q != '0);

endmodule

// File: rtl/udp_tx_fields.sv
module udp_tx_fields
  import udp_tx_pkg::*;
#(
  parameter int          LEN_W     = 11,
  parameter logic [15:0] BASE_CSUM = 16'h0000
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [15:0]      tot_len_o,
  output logic [15:0]      hdr_csum_o,
  output logic [15:0]      udp_len_o
);

  logic [15:0] len_ext;

  assign len_ext    = 16'(len_i);
  assign tot_len_o  = 16'(IP_BYTES + UDP_BYTES) + len_ext;
  assign udp_len_o  = 16'(UDP_BYTES) + len_ext;
  // total length is narrow, so the first word addition never carries
  assign hdr_csum_o = BASE_CSUM - len_ext;

endmodule

// File: rtl/udp_tx_outsel.sv
module udp_tx_outsel
  import udp_tx_pkg::*;
#(
  parameter int                       IDX_W     = 12,
  parameter logic [HDR_BYTES*8-1:0]   HDR_TABLE = '0
) (
  input  logic             busy_i,
  input  logic             in_payload_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       usr_data_i,
  input  logic [15:0]      tot_len_i,
  input  logic [15:0]      hdr_csum_i,
  input  logic [15:0]      udp_len_i,
  output logic [7:0]       tx_data_o
);

  localparam int POS_W = $clog2(HDR_BYTES);

  logic [7:0]       tbl [HDR_BYTES];
  fld_sel_e         sel;
  logic             hi_byte;
  logic [15:0]      fld;
  logic [7:0]       hdr_byte;
  logic [POS_W-1:0] pos;

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_tbl
    assign tbl[g] = HDR_TABLE[(HDR_BYTES-1-g)*8 +: 8];
  end

  assign pos = idx_i[POS_W-1:0];

  // override controller: choose the field source by header position
  always_comb begin
    sel     = SEL_TABLE;
    hi_byte = 1'b0;
    if (idx_i == IDX_W'(TOTLEN_POS) || idx_i == IDX_W'(TOTLEN_POS + 1)) begin
      sel     = SEL_TOTLEN;
      hi_byte = (idx_i == IDX_W'(TOTLEN_POS));
    end else if (idx_i == IDX_W'(CSUM_POS) || idx_i == IDX_W'(CSUM_POS + 1)) begin
      sel     = SEL_CSUM;
      hi_byte = (idx_i == IDX_W'(CSUM_POS));
    end else if (idx_i == IDX_W'(UDPLEN_POS) || idx_i == IDX_W'(UDPLEN_POS + 1)) begin
      sel     = SEL_UDPLEN;
      hi_byte = (idx_i == IDX_W'(UDPLEN_POS));
    end
  end

  always_comb begin
    unique case (sel)
      SEL_TOTLEN: fld = tot_len_i;
      SEL_CSUM:   fld = hdr_csum_i;
      SEL_UDPLEN: fld = udp_len_i;
      default:    fld = 16'h0000;
    endcase
  end

  always_comb begin
    if (sel == SEL_TABLE) hdr_byte = tbl[pos];
    else if (hi_byte)     hdr_byte = fld[15:8];
    else                  hdr_byte = fld[7:0];
  end

  always_comb begin
    if (!busy_i)          tx_data_o = 8'h00;
    else if (in_payload_i) tx_data_o = usr_data_i;
    else                  tx_data_o = hdr_byte;
  end

endmodule

// File: rtl/udp_frame_tx.sv
module udp_frame_tx
  import udp_tx_pkg::*;
#(
  parameter int          LEN_W     = 11,
  parameter int          REQ_LEAD  = 2,
  parameter logic [47:0] DST_MAC   = 48'h00_1B_21_3A_4C_5E,
  parameter logic [47:0] SRC_MAC   = 48'h02_00_00_00_00_01,
  parameter logic [31:0] SRC_IP    = 32'hC0A8_010A,
  parameter logic [31:0] DST_IP    = 32'hC0A8_0101,
  parameter logic [15:0] SRC_PORT  = 16'd4660,
  parameter logic [15:0] DST_PORT  = 16'd9000,
  parameter logic [15:0] IP_IDENT  = 16'h0000,
  parameter logic [15:0] IP_FLAGS  = 16'h4000,
  parameter logic [7:0]  IP_TTL    = 8'd64,
  parameter logic [15:0] BASE_CSUM = base_csum(IP_IDENT, IP_FLAGS, IP_TTL, SRC_IP, DST_IP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       usr_data_i,
  output logic             data_req_o,
  output logic [7:0]       tx_data_o,
  output logic             sof_n_o,
  output logic             eof_n_o,
  output logic             src_rdy_n_o
);

  localparam int IDX_W = $clog2(HDR_BYTES + (1 << LEN_W));

  localparam logic [HDR_BYTES*8-1:0] HDR_TABLE = {
    DST_MAC, SRC_MAC, ETH_TYPE,
    IP_VER_IHL, IP_TOS, 16'h0000, IP_IDENT, IP_FLAGS,
    IP_TTL, IP_PROTO, 16'h0000, SRC_IP, DST_IP,
    SRC_PORT, DST_PORT, 16'h0000, 16'h0000
  };

  logic             busy;
  logic             in_payload;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_q;
  logic [15:0]      tot_len;
  logic [15:0]      hdr_csum;
  logic [15:0]      udp_len;

  udp_tx_seq #(
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W),
    .REQ_LEAD (REQ_LEAD)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .len_i        (len_i),
    .busy_o       (busy),
    .idx_o        (idx),
    .len_o        (len_q),
    .in_payload_o (in_payload),
    .sof_n_o      (sof_n_o),
    .eof_n_o      (eof_n_o),
    .src_rdy_n_o  (src_rdy_n_o),
    .data_req_o   (data_req_o)
  );

  udp_tx_fields #(
    .LEN_W     (LEN_W),
    .BASE_CSUM (BASE_CSUM)
  ) u_fields (
    .len_i      (len_q),
    .tot_len_o  (tot_len),
    .hdr_csum_o (hdr_csum),
    .udp_len_o  (udp_len)
  );

  udp_tx_outsel #(
    .IDX_W     (IDX_W),
    .HDR_TABLE (HDR_TABLE)
  ) u_outsel (
    .busy_i       (busy),
    .in_payload_i (in_payload),
    .idx_i        (idx),
    .usr_data_i   (usr_data_i),
    .tot_len_i    (tot_len),
    .hdr_csum_i   (hdr_csum),
    .udp_len_i    (udp_len),
    .tx_data_o    (tx_data_o)
  );

endmodule

// File: rtl/udp_frame_tx_chk.sv
module udp_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       data_req_o,
  input logic [7:0] tx_data_o,
  input logic       sof_n_o,
  input logic       eof_n_o,
  input logic       src_rdy_n_o
);

  // R2
  sof_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_n_o |-> ($past(start_i) && $past(src_rdy_n_o)));

  // R9
  sof_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_n_o |-> !src_rdy_n_o);

  // R9
  frame_ends_at_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_rdy_n_o && eof_n_o) |=> !src_rdy_n_o);

  // R11
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_n_o |=> (src_rdy_n_o && sof_n_o));

  // R6
  req_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req_o |-> ##2 (!src_rdy_n_o && sof_n_o));

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req_o |=> !data_req_o);

  // R8
  sof_eof_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_n_o |-> eof_n_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rdy_n_o |-> (tx_data_o == 8'h00 && !data_req_o && sof_n_o && eof_n_o));

endmodule

bind udp_frame_tx udp_frame_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .data_req_o  (data_req_o),
  .tx_data_o   (tx_data_o),
  .sof_n_o     (sof_n_o),
  .eof_n_o     (eof_n_o),
  .src_rdy_n_o (src_rdy_n_o)
);

// File: tb/udp_frame_tx_bench.sv
`timescale 1ns/1ps
module udp_frame_tx_bench;

  localparam int HDR = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] len_i = '0;
  logic [7:0]  usr_data_i = '0;
  logic        data_req_o;
  logic [7:0]  tx_data_o;
  logic        sof_n_o;
  logic        eof_n_o;
  logic        src_rdy_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    bit         sof;
    bit         eof;
    bit         req;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  udp_frame_tx u_udp_frame_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .usr_data_i  (usr_data_i),
    .data_req_o  (data_req_o),
    .tx_data_o   (tx_data_o),
    .sof_n_o     (sof_n_o),
    .eof_n_o     (eof_n_o),
    .src_rdy_n_o (src_rdy_n_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] oadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // R4 expected checksum: full end-around-carry sum over the header words
  function automatic logic [15:0] ref_csum(input int l);
    logic [15:0] w[10] = '{16'h4500, 16'(28 + l), 16'h0000, 16'h4000, 16'h4011,
                           16'h0000, 16'hC0A8, 16'h010A, 16'hC0A8, 16'h0101};
    logic [15:0] acc = 16'h0000;
    for (int i = 0; i < 10; i++) acc = oadd(acc, w[i]);
    return ~acc;
  endfunction

  function automatic logic [7:0] hdr_byte(input int l, input int i);
    logic [8*HDR-1:0] h;
    h = {48'h001B213A4C5E, 48'h020000000001, 16'h0800,
         8'h45, 8'h00, 16'(28 + l), 16'h0000, 16'h4000, 8'd64, 8'h11, ref_csum(l),
         32'hC0A8010A, 32'hC0A80101,
         16'd4660, 16'd9000, 16'(8 + l), 16'h0000};
    return h[(HDR-1-i)*8 +: 8];
  endfunction

  function automatic string tag_of(input int i);
    if (i == 16 || i == 17) return "R3";
    if (i == 24 || i == 25) return "R4";
    if (i >= 38 && i < 42)  return "R5";
    if (i >= 42)            return "R7";
    return "R1";
  endfunction

  function automatic logic [7:0] pay(input int l, input int j);
    return 8'(j * 7 + l + 3);
  endfunction

  // driver: pushes the expected frame, then drives request, junk and payload
  task automatic send_frame(input int l, input bit poke_mid, input bit poke_last);
    for (int i = 0; i < HDR + l; i++) begin
      exp_t e;
      e.data = (i < HDR) ? hdr_byte(l, i) : pay(l, i - HDR);
      e.sof  = (i == 0);
      e.eof  = (i == HDR + l - 1);
      e.req  = (i == HDR - 2) && (l != 0);
      e.tag  = tag_of(i);
      exp_q.push_back(e);
    end
    start_i = 1'b1;
    len_i   = 11'(l);
    @(posedge clk); #1;
    start_i = 1'b0;
    len_i   = 11'(l ^ 11'h2A5);   // R10: length changes after capture
    for (int i = 0; i < HDR + l; i++) begin
      usr_data_i = (i < HDR) ? (8'hA5 ^ 8'(i)) : pay(l, i - HDR);
      start_i    = (poke_mid && i == 20) || (poke_last && i == HDR + l - 1);  // R11
      @(posedge clk); #1;
    end
    start_i    = 1'b0;
    usr_data_i = 8'h5A;   // R7: junk after the payload window
  endtask

  // monitor: compares each produced byte with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!src_rdy_n_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected frame byte", tx_data_o, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(tx_data_o == e.data, e.tag, tx_data_o, e.data);
          check(sof_n_o == !e.sof, "R2 sof_n", sof_n_o, !e.sof);
          check(eof_n_o == !e.eof, "R8 eof_n", eof_n_o, !e.eof);
          check(data_req_o == e.req, "R6 data_req", data_req_o, e.req);
        end
      end else begin
        check(tx_data_o == 8'h00 && !data_req_o && sof_n_o && eof_n_o,
              "R9 idle outputs", {tx_data_o, data_req_o, sof_n_o, eof_n_o}, 8'h03 << 0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    // R12 reset state
    check(sof_n_o && eof_n_o && src_rdy_n_o && !data_req_o && tx_data_o == 8'h00,
          "R12 reset", {sof_n_o, eof_n_o, src_rdy_n_o, data_req_o}, 4'hE);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #4;
    check(sof_n_o && eof_n_o && src_rdy_n_o && !data_req_o && tx_data_o == 8'h00,
          "R12 after reset", {sof_n_o, eof_n_o, src_rdy_n_o, data_req_o}, 4'hE);
    @(posedge clk); #1;

    send_frame(0, 1'b0, 1'b0);        // R5 R8 empty payload
    repeat (3) @(posedge clk); #1;
    send_frame(1, 1'b1, 1'b1);        // R11 starts ignored mid frame and on last byte
    repeat (4) @(posedge clk); #1;
    send_frame(18, 1'b1, 1'b0);
    send_frame(64, 1'b0, 1'b0);       // R11 back-to-back with one idle cycle
    send_frame(5, 1'b0, 1'b0);
    repeat (2) @(posedge clk); #1;
    send_frame(1472, 1'b0, 1'b0);     // R4 large payload
    send_frame(2047, 1'b0, 1'b0);     // R3 R4 maximum length
    repeat (10) @(posedge clk);
    #4;
    check(exp_q.size() == 0, "R11 all frames emitted", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule